// File: doc/BRIEF.md
# Host-to-Processor Command Mailbox with Two-Wire Serial Slave

This block is a small register mailbox between an external USB microcontroller and an on-chip processor. The external controller reaches it as an I2C slave at one fixed 7-bit address. The processor reaches it through a simple memory-mapped word bus. The block holds three 32-bit inbound words and three 32-bit outbound words. The host writes the inbound words and the processor reads them. The processor writes the outbound words and the host reads them.

Each side has its own interrupt. The processor interrupt rises when the host completes inbound word 0. It stays high until software clears it through a status word. The host interrupt is a doorbell. It rises on a processor write to outbound word 0 and drops once the host has read out the final byte of the outbound bank.

Every serial transaction starts with a byte index. The index points into a 24-byte window, and the pointer then advances by one for each byte moved. Inbound words are staged and committed whole, so the processor never sees a half-written word.

Top module: `hostlink_mailbox`

## Requirements
- R1: After reset both interrupt lines are low, `sda_oe` is low, and every word readable on the processor bus reads 0.
- R2: The slave ACKs a START followed by the bus address `DEV_ADDR` (default 7'h42, so 8'h84 to write and 8'h85 to read). It also ACKs every later byte it receives. It NACKs any other address and then ignores the bus until the next START.
- R3: The first byte written after the address is the byte index. Indices 0–11 select the inbound bytes and 12–23 select the outbound bytes, with word = index/4 and lane = index%4. An index of 24 or more selects 0. The pointer advances by one per byte moved in either direction and wraps from 23 to 0.
- R4: Bytes are little-endian: lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R5: An inbound word changes only when its lane-3 byte is written. At that moment every lane written in the current transaction takes the new value and every other lane keeps its old value.
- R6: A STOP or repeated START discards any lanes that are staged but not yet committed, so the word keeps its previous value.
- R7: `irq_cpu` rises after a commit of inbound word 0. Commits of inbound words 1 and 2 do not raise it.
- R8: A processor write to address 6 with bit 0 set clears `irq_cpu`. A write with bit 0 clear leaves it set.
- R9: A processor write to address 3 (outbound word 0) raises `irq_host`. Writes to addresses 4 and 5 do not.
- R10: `irq_host` stays high until the host has shifted out byte index 23, and then it drops.
- R11: Host writes to indices 12–23 and processor writes to addresses 0–2 do not change any register.
- R12: The processor map is: addresses 0–2 are inbound words 0–2, addresses 3–5 are outbound words 0–2, and address 6 is status (bit 0 = `irq_cpu`, bit 1 = `irq_host`). All other addresses read 0.
- R13: SDA is driven open-drain, with `sda_oe` high pulling the line low. `sda_oe` changes only while SCL is low. Both bus inputs pass through a synchroniser before START and STOP detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | Pull SDA low when high |
| cpu_addr | input | 3 | Processor word address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data (combinational) |
| irq_cpu | output | 1 | Interrupt to the processor |
| irq_host | output | 1 | Doorbell to the external controller |

## Verification
The hardest states to reach are a transaction cut off between the lane-0 and lane-3 bytes, and a doorbell clear that lands on exactly one byte index. The bench drives byte-level START, repeated START, STOP, write-byte and read-byte tasks. With these it can stop a write after two bytes, or restart it after one, and then read the word back. It also reads the processor bus while SCL is held low halfway through a word. For the doorbell, the bench reads eleven outbound bytes, samples `irq_host`, and only then fetches the twelfth byte. A separate wrapped read starting at index 23 shows the pointer returning to 0.

// File: rtl/hlmb_pkg.sv
package hlmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } eng_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_INDEX,
    PH_DATA
  } eng_phase_t;
endpackage

// File: rtl/hlmb_sync.sv
// Multi-stage input synchroniser; also returns the previous synchronised
// sample so the caller can find edges.
module hlmb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] pipe_q [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s <= STAGES; s++) pipe_q[s] <= '1;
    end else begin
      pipe_q[0] <= pin_i;
      for (int s = 1; s <= STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];
  assign prev_o  = pipe_q[STAGES];
endmodule

// File: rtl/hlmb_i2c_engine.sv
// Serial slave protocol engine: address match, index byte, byte writes and
// byte reads with a self-advancing pointer.
module hlmb_i2c_engine
  import hlmb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42,
  parameter int         BYTES    = 24,
  parameter int         PTR_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_done,
  output logic [PTR_W-1:0] rd_addr
);
  eng_state_t       st_q, st_n;
  eng_phase_t       ph_q, ph_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       rx_q, rx_n;
  logic [7:0]       tx_q, tx_n;
  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic             rw_q, rw_n;
  logic             mack_q, mack_n;
  logic             oe_q, oe_n;
  logic             wstb_q, wstb_n;
  logic [PTR_W-1:0] waddr_q, waddr_n;
  logic [7:0]       wdat_q, wdat_n;
  logic             rdone_q, rdone_n;
  logic [PTR_W-1:0] raddr_q, raddr_n;

  assign ptr_inc = (ptr_q == PTR_W'(BYTES-1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    cnt_n   = cnt_q;
    rx_n    = rx_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    mack_n  = mack_q;
    wstb_n  = 1'b0;
    waddr_n = waddr_q;
    wdat_n  = wdat_q;
    rdone_n = 1'b0;
    raddr_n = raddr_q;
    if (start_det) begin
      st_n  = ST_RX;
      ph_n  = PH_ADDR;
      cnt_n = '0;
    end else if (stop_det) begin
      st_n = ST_IDLE;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != 4'd8) begin
            rx_n  = {rx_q[6:0], sda_lvl};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            st_n = ST_RX_ACK;
            case (ph_q)
              PH_ADDR: begin
                if (rx_q[7:1] != DEV_ADDR) st_n = ST_WAIT;
                else                       rw_n = rx_q[0];
              end
              PH_INDEX: ptr_n = (rx_q < 8'(BYTES)) ? rx_q[PTR_W-1:0] : '0;
              default: begin
                wstb_n  = 1'b1;
                waddr_n = ptr_q;
                wdat_n  = rx_q;
                ptr_n   = ptr_inc;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (ph_q == PH_ADDR && rw_q) begin
              st_n = ST_TX;
              tx_n = rd_data;
            end else begin
              st_n = ST_RX;
              ph_n = (ph_q == PH_ADDR) ? PH_INDEX : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              st_n    = ST_TX_ACK;
              rdone_n = 1'b1;
              raddr_n = ptr_q;
              ptr_n   = ptr_inc;
            end else begin
              tx_n  = {tx_q[6:0], 1'b0};
              cnt_n = cnt_q + 4'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n  = ST_TX;
              tx_n  = rd_data;
              cnt_n = '0;
            end else begin
              st_n = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
    oe_n = (st_n == ST_RX_ACK) || (st_n == ST_TX && !tx_n[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_q    <= PH_ADDR;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wstb_q  <= 1'b0;
      waddr_q <= '0;
      wdat_q  <= '0;
      rdone_q <= 1'b0;
      raddr_q <= '0;
    end else begin
      st_q    <= st_n;
      ph_q    <= ph_n;
      cnt_q   <= cnt_n;
      rx_q    <= rx_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      mack_q  <= mack_n;
      oe_q    <= oe_n;
      wstb_q  <= wstb_n;
      waddr_q <= waddr_n;
      wdat_q  <= wdat_n;
      rdone_q <= rdone_n;
      raddr_q <= raddr_n;
    end
  end

  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;
  assign wr_stb  = wstb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdat_q;
  assign rd_done = rdone_q;
  assign rd_addr = raddr_q;
endmodule

// File: rtl/hlmb_regs.sv
// Inbound and outbound word banks, lane staging, interrupt flags and the
// processor-side word bus.
module hlmb_regs #(
  parameter int WORDS  = 3,
  parameter int PTR_W  = 5,
  parameter int CPU_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              wr_stb,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [7:0]        rd_data,
  input  logic              rd_done,
  input  logic [PTR_W-1:0]  rd_addr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq_cpu,
  output logic              irq_host
);
  localparam int IN_BYTES = WORDS * 4;
  localparam int LAST_IDX = 2 * WORDS * 4 - 1;
  localparam int STATUS   = 2 * WORDS;
  localparam int WW       = PTR_W - 2;

  logic [31:0] in_q  [WORDS];
  logic [31:0] in_n  [WORDS];
  logic [31:0] out_q [WORDS];
  logic [31:0] out_n [WORDS];
  logic [31:0] bank  [2*WORDS];
  logic [31:0] stage_q, stage_n;
  logic [3:0]  lanes_q, lanes_n;
  logic        irqc_q, irqc_n, irqh_q, irqh_n;
  logic        commit0;
  logic [WW-1:0] wr_word, rd_word;
  logic [1:0]    wr_lane, rd_lane;
  logic [31:0]   rd_word_val;

  assign wr_word = wr_addr[PTR_W-1:2];
  assign wr_lane = wr_addr[1:0];
  assign rd_word = rd_ptr[PTR_W-1:2];
  assign rd_lane = rd_ptr[1:0];

  for (genvar g = 0; g < 2*WORDS; g++) begin : g_bank
    if (g < WORDS) begin : g_in
      assign bank[g] = in_q[g];
    end else begin : g_out
      assign bank[g] = out_q[g-WORDS];
    end
  end

  always_comb begin
    stage_n = stage_q;
    lanes_n = lanes_q;
    commit0 = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      in_n[i]  = in_q[i];
      out_n[i] = out_q[i];
    end
    if (abort) begin
      lanes_n = '0;
    end else if (wr_stb && wr_addr < PTR_W'(IN_BYTES)) begin
      stage_n[{wr_lane, 3'b000} +: 8] = wr_data;
      lanes_n[wr_lane] = 1'b1;
      if (wr_lane == 2'd3) begin
        for (int i = 0; i < WORDS; i++) begin
          if (wr_word == WW'(i)) begin
            for (int b = 0; b < 4; b++) begin
              if (lanes_n[b]) in_n[i][b*8 +: 8] = stage_n[b*8 +: 8];
            end
          end
        end
        lanes_n = '0;
        commit0 = (wr_word == '0);
      end
    end
    if (cpu_wr) begin
      for (int i = 0; i < WORDS; i++) begin
        if (cpu_addr == CPU_AW'(WORDS + i)) out_n[i] = cpu_wdata;
      end
    end
    irqc_n = commit0 ||
             (irqc_q && !(cpu_wr && cpu_addr == CPU_AW'(STATUS) && cpu_wdata[0]));
    irqh_n = (cpu_wr && cpu_addr == CPU_AW'(WORDS)) ||
             (irqh_q && !(rd_done && rd_addr == PTR_W'(LAST_IDX)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        in_q[i]  <= '0;
        out_q[i] <= '0;
      end
      stage_q <= '0;
      lanes_q <= '0;
      irqc_q  <= 1'b0;
      irqh_q  <= 1'b0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        in_q[i]  <= in_n[i];
        out_q[i] <= out_n[i];
      end
      stage_q <= stage_n;
      lanes_q <= lanes_n;
      irqc_q  <= irqc_n;
      irqh_q  <= irqh_n;
    end
  end

  always_comb begin
    rd_word_val = '0;
    for (int i = 0; i < 2*WORDS; i++) begin
      if (rd_word == WW'(i)) rd_word_val = bank[i];
    end
    rd_data = rd_word_val[{rd_lane, 3'b000} +: 8];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < 2*WORDS; i++) begin
      if (cpu_addr == CPU_AW'(i)) cpu_rdata = bank[i];
    end
    if (cpu_addr == CPU_AW'(STATUS)) cpu_rdata = {30'b0, irqh_q, irqc_q};
  end

  assign irq_cpu  = irqc_q;
  assign irq_host = irqh_q;
endmodule

// File: rtl/hostlink_mailbox.sv
module hostlink_mailbox #(
  parameter logic [6:0] DEV_ADDR    = 7'h42,
  parameter int         WORDS       = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        CPU_AW      = $clog2(2*WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq_cpu,
  output logic              irq_host
);
  localparam int BYTES = 2 * WORDS * 4;
  localparam int PTR_W = $clog2(BYTES);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic [1:0] bus_lvl, bus_prev;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] eng_ptr, eng_wr_addr, eng_rd_addr;
  logic [7:0]       eng_wr_data, reg_rd_data;
  logic             eng_wr_stb, eng_rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  hlmb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .pin_i   ({scl_i, sda_i}),
    .level_o (bus_lvl),
    .prev_o  (bus_prev)
  );

  assign scl_rise  = bus_lvl[1] & ~bus_prev[1];
  assign scl_fall  = ~bus_lvl[1] & bus_prev[1];
  assign start_det = bus_lvl[1] & bus_prev[1] & bus_prev[0] & ~bus_lvl[0];
  assign stop_det  = bus_lvl[1] & bus_prev[1] & ~bus_prev[0] & bus_lvl[0];

  hlmb_i2c_engine #(.DEV_ADDR(DEV_ADDR), .BYTES(BYTES), .PTR_W(PTR_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_lvl   (bus_lvl[0]),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (reg_rd_data),
    .ptr       (eng_ptr),
    .sda_oe    (sda_oe),
    .wr_stb    (eng_wr_stb),
    .wr_addr   (eng_wr_addr),
    .wr_data   (eng_wr_data),
    .rd_done   (eng_rd_done),
    .rd_addr   (eng_rd_addr)
  );

  hlmb_regs #(.WORDS(WORDS), .PTR_W(PTR_W), .CPU_AW(CPU_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .abort     (start_det | stop_det),
    .wr_stb    (eng_wr_stb),
    .wr_addr   (eng_wr_addr),
    .wr_data   (eng_wr_data),
    .rd_ptr    (eng_ptr),
    .rd_data   (reg_rd_data),
    .rd_done   (eng_rd_done),
    .rd_addr   (eng_rd_addr),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .irq_cpu   (irq_cpu),
    .irq_host  (irq_host)
  );
endmodule

// File: rtl/hlmb_checker.sv
module hlmb_checker #(
  parameter int WORDS  = 3,
  parameter int PTR_W  = 5,
  parameter int CPU_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic [31:0]       cpu_wdata,
  input logic              irq_cpu,
  input logic              irq_host,
  input logic              wr_stb,
  input logic [PTR_W-1:0]  wr_addr,
  input logic              rd_done,
  input logic [PTR_W-1:0]  rd_addr
);
  localparam int LAST_IDX = 2 * WORDS * 4 - 1;
  localparam int LANE3_W0 = 3;

  // R13: the open-drain enable only moves while the clock line is low
  p_sda_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R7: processor interrupt rises only after the lane-3 byte of inbound word 0
  p_cpu_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_cpu) |-> ($past(wr_stb) && $past(wr_addr) == PTR_W'(LANE3_W0)));

  // R8: processor interrupt holds until a clearing status write
  p_cpu_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cpu && !(cpu_wr && cpu_addr == CPU_AW'(2*WORDS) && cpu_wdata[0]))
      |=> irq_cpu);

  // R9: a write to outbound word 0 rings the doorbell
  p_host_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == CPU_AW'(WORDS)) |=> irq_host);

  // R10: doorbell holds until the final outbound byte has been sent
  p_host_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_host && !(rd_done && rd_addr == PTR_W'(LAST_IDX))) |=> irq_host);

  // R10: doorbell drops only through that final byte
  p_host_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_host) |-> ($past(rd_done) && $past(rd_addr) == PTR_W'(LAST_IDX)));
endmodule

bind hostlink_mailbox hlmb_checker #(
  .WORDS  (WORDS),
  .PTR_W  (PTR_W),
  .CPU_AW (CPU_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .cpu_addr  (cpu_addr),
  .cpu_wr    (cpu_wr),
  .cpu_wdata (cpu_wdata),
  .irq_cpu   (irq_cpu),
  .irq_host  (irq_host),
  .wr_stb    (eng_wr_stb),
  .wr_addr   (eng_wr_addr),
  .rd_done   (eng_rd_done),
  .rd_addr   (eng_rd_addr)
);

// File: tb/hostlink_mailbox_test.sv
`timescale 1ns/1ps
module hostlink_mailbox_test;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_bus;
  logic        sda_oe;
  logic [2:0]  cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq_cpu, irq_host;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_val[$];
  string       exp_tag[$];
  logic [31:0] obs_val[$];

  always #2.5 clk = ~clk;

  assign sda_bus = ~(m_low | sda_oe);

  hostlink_mailbox uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_cpu(irq_cpu), .irq_host(irq_host)
  );

  // ---- scoreboard ----
  task automatic expect_item(input string tag, input logic [31:0] v);
    exp_tag.push_back(tag);
    exp_val.push_back(v);
  endtask

  task automatic observe(input logic [31:0] v);
    obs_val.push_back(v);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      while (obs_val.size() > 0) begin
        logic [31:0] a;
        a = obs_val.pop_front();
        checks++;
        if (exp_val.size() == 0) begin
          errors++;
          $display("FAIL unexpected item: actual %h expected none", a);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_val.pop_front();
          t = exp_tag.pop_front();
          if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, a, e);
          end
        end
      end
    end
  end

  // ---- bus master ----
  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_low = 1'b0; scl_m = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_rstart();
    m_low = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    m_low = 1'b1; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    m_low = 1'b0; hold(2*Q);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; hold(Q);
      scl_m = 1'b1; hold(2*Q);
      scl_m = 1'b0; hold(Q);
    end
    m_low = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    ack_n = sda_bus; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic i2c_rbyte(input logic last, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q);
      b[i] = sda_bus; hold(Q);
      scl_m = 1'b0; hold(Q);
    end
    m_low = ~last; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    scl_m = 1'b0; hold(Q);
    m_low = 1'b0;
  endtask

  task automatic wr_ack(input string tag, input logic [7:0] b, input logic exp_nack);
    logic a;
    expect_item(tag, {31'b0, exp_nack});
    i2c_wbyte(b, a);
    observe({31'b0, a});
  endtask

  task automatic rd_chk(input string tag, input logic last, input logic [7:0] e);
    logic [7:0] b;
    expect_item(tag, {24'b0, e});
    i2c_rbyte(last, b);
    observe({24'b0, b});
  endtask

  // ---- processor bus ----
  task automatic cpu_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    hold(2);
  endtask

  task automatic cpu_chk(input string tag, input logic [2:0] a, input logic [31:0] e);
    @(negedge clk);
    cpu_addr = a;
    #1;
    expect_item(tag, e);
    observe(cpu_rdata);
  endtask

  task automatic pin_chk(input string tag, input logic act, input logic e);
    @(negedge clk);
    expect_item(tag, {31'b0, e});
    observe({31'b0, act});
  endtask

  // ---- stimulus ----
  initial begin : driver
    hold(10);
    rst_n = 1'b1;
    hold(10);

    // R1 reset state
    pin_chk("R1 irq_cpu", irq_cpu, 1'b0);
    pin_chk("R1 irq_host", irq_host, 1'b0);
    pin_chk("R1 sda_oe", sda_oe, 1'b0);
    for (int a = 0; a < 7; a++) cpu_chk("R1 word", 3'(a), 32'h0);

    // R2 R4 R7: full word 0 written little-endian
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h00, 1'b0);
    wr_ack("R2 data ack", 8'h11, 1'b0);
    wr_ack("R2 data ack", 8'h22, 1'b0);
    wr_ack("R2 data ack", 8'h33, 1'b0);
    wr_ack("R2 data ack", 8'h44, 1'b0);
    i2c_stop();
    cpu_chk("R4 inbound0 order", 3'd0, 32'h44332211);
    pin_chk("R7 irq_cpu after word0", irq_cpu, 1'b1);
    cpu_chk("R12 status", 3'd6, 32'h1);
    pin_chk("R13 sda released", sda_oe, 1'b0);

    // R8 clearing
    cpu_write(3'd6, 32'h0);
    pin_chk("R8 bit0 clear has no effect", irq_cpu, 1'b1);
    cpu_write(3'd6, 32'h1);
    pin_chk("R8 cleared", irq_cpu, 1'b0);

    // R2 foreign address
    i2c_start();
    wr_ack("R2 foreign nack", 8'h90, 1'b1);
    i2c_stop();
    cpu_chk("R2 no effect", 3'd0, 32'h44332211);

    // R5 atomic commit of word 1
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h04, 1'b0);
    wr_ack("R2 data ack", 8'hA1, 1'b0);
    wr_ack("R2 data ack", 8'hA2, 1'b0);
    wr_ack("R2 data ack", 8'hA3, 1'b0);
    cpu_chk("R5 word1 mid-write unchanged", 3'd1, 32'h0);
    wr_ack("R2 data ack", 8'hA4, 1'b0);
    cpu_chk("R5 word1 committed", 3'd1, 32'hA4A3A2A1);
    i2c_stop();
    pin_chk("R7 word1 leaves irq_cpu low", irq_cpu, 1'b0);

    // R6 abort by stop
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h08, 1'b0);
    wr_ack("R2 data ack", 8'h55, 1'b0);
    wr_ack("R2 data ack", 8'h66, 1'b0);
    i2c_stop();
    cpu_chk("R6 stop abort keeps word2", 3'd2, 32'h0);

    // R6 abort by repeated start, then lane 3 alone
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h08, 1'b0);
    wr_ack("R2 data ack", 8'h77, 1'b0);
    i2c_rstart();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h0B, 1'b0);
    wr_ack("R2 data ack", 8'h99, 1'b0);
    i2c_stop();
    cpu_chk("R6 restart discards staged lane", 3'd2, 32'h99000000);

    // R3 R5 pointer runs over a word boundary
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h02, 1'b0);
    wr_ack("R2 data ack", 8'hB2, 1'b0);
    wr_ack("R2 data ack", 8'hB3, 1'b0);
    wr_ack("R2 data ack", 8'hC0, 1'b0);
    wr_ack("R2 data ack", 8'hC1, 1'b0);
    wr_ack("R2 data ack", 8'hC2, 1'b0);
    wr_ack("R2 data ack", 8'hC3, 1'b0);
    i2c_stop();
    cpu_chk("R5 partial-lane merge word0", 3'd0, 32'hB3B22211);
    cpu_chk("R3 increment into word1", 3'd1, 32'hC3C2C1C0);
    pin_chk("R7 irq_cpu again", irq_cpu, 1'b1);
    cpu_write(3'd6, 32'h1);

    // R11 processor cannot write inbound
    cpu_write(3'd1, 32'hDEADBEEF);
    cpu_chk("R11 inbound write ignored", 3'd1, 32'hC3C2C1C0);

    // R9 doorbell
    cpu_write(3'd4, 32'h0A0B0C0D);
    cpu_write(3'd5, 32'h01020304);
    pin_chk("R9 words 4/5 silent", irq_host, 1'b0);
    cpu_write(3'd3, 32'h90807060);
    pin_chk("R9 doorbell", irq_host, 1'b1);
    cpu_chk("R12 outbound0", 3'd3, 32'h90807060);
    cpu_chk("R12 status doorbell bit", 3'd6, 32'h2);
    cpu_chk("R12 unmapped", 3'd7, 32'h0);

    // R10 host reads outbound bank
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h0C, 1'b0);
    i2c_rstart();
    wr_ack("R2 read address ack", 8'h85, 1'b0);
    rd_chk("R4 out0 b0", 1'b0, 8'h60);
    rd_chk("R4 out0 b1", 1'b0, 8'h70);
    rd_chk("R4 out0 b2", 1'b0, 8'h80);
    rd_chk("R4 out0 b3", 1'b0, 8'h90);
    rd_chk("R3 out1 b0", 1'b0, 8'h0D);
    rd_chk("R3 out1 b1", 1'b0, 8'h0C);
    rd_chk("R3 out1 b2", 1'b0, 8'h0B);
    rd_chk("R3 out1 b3", 1'b0, 8'h0A);
    rd_chk("R3 out2 b0", 1'b0, 8'h04);
    rd_chk("R3 out2 b1", 1'b0, 8'h03);
    rd_chk("R3 out2 b2", 1'b0, 8'h02);
    pin_chk("R10 doorbell held", irq_host, 1'b1);
    rd_chk("R3 out2 b3", 1'b1, 8'h01);
    i2c_stop();
    pin_chk("R10 doorbell cleared", irq_host, 1'b0);

    // R11 host cannot write outbound
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h0C, 1'b0);
    wr_ack("R2 data ack", 8'hFF, 1'b0);
    wr_ack("R2 data ack", 8'hFF, 1'b0);
    wr_ack("R2 data ack", 8'hFF, 1'b0);
    wr_ack("R2 data ack", 8'hFF, 1'b0);
    i2c_stop();
    cpu_chk("R11 outbound write ignored", 3'd3, 32'h90807060);
    pin_chk("R11 no irq_cpu", irq_cpu, 1'b0);

    // R3 wrap 23 -> 0 and R10 clear from a wrapped read
    cpu_write(3'd3, 32'h90807060);
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h17, 1'b0);
    i2c_rstart();
    wr_ack("R2 read address ack", 8'h85, 1'b0);
    rd_chk("R3 byte 23", 1'b0, 8'h01);
    rd_chk("R3 wrapped byte 0", 1'b1, 8'h11);
    i2c_stop();
    pin_chk("R10 cleared on byte 23", irq_host, 1'b0);

    // R3 out-of-range index selects 0
    i2c_start();
    wr_ack("R2 address ack", 8'h84, 1'b0);
    wr_ack("R3 index ack", 8'h40, 1'b0);
    i2c_rstart();
    wr_ack("R2 read address ack", 8'h85, 1'b0);
    rd_chk("R3 large index", 1'b1, 8'h11);
    i2c_stop();
    pin_chk("R13 sda released", sda_oe, 1'b0);

    hold(5);
    if (exp_val.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_val.size());
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule